// File: doc/BRIEF.md
# Flash Program-Start Guard

This block sits in front of the program state machine of a flash memory model. It decides whether a write strobe may start a program cycle. It watches four inputs: the active-low chip enable, output enable and write enable, and a digital supply-good flag. A single-cycle start pulse is raised only when every gate condition holds. The write strobe is the interval during which chip enable and write enable are both low.

All four inputs are first brought into the block clock domain through a chain of flops. Three rules then apply. The first is a static inhibit: a strobe gives nothing if chip enable or write enable is high, or if output enable is low. The second is a deglitch filter: a strobe shorter than a minimum number of clock cycles is dropped. The third is a power-up lockout: once supply-good rises, programming stays blocked for a fixed number of cycles. Losing supply-good restarts that count. A strobe that passes every rule produces its pulse when it is released, not when it starts.

Top module: `flash_prog_guard`

## Requirements
- R1: After synchronous reset, `prog_start` is low. It stays low until a strobe has been qualified after the lockout has expired.
- R2: A strobe that qualifies produces exactly one `prog_start` pulse, one cycle wide. The pulse appears on the third rising clock edge after the input edge that releases the strobe (two synchronizer flops plus one output flop). The strobe is defined as `ce_n` and `we_n` both low for at least `MIN_LOW_CYCLES` cycles, with `oe_n` high throughout and the lockout expired.
- R3: A strobe shorter than `MIN_LOW_CYCLES` clock cycles produces no pulse. This holds whether write enable or chip enable ends the strobe.
- R4: If `oe_n` is low in any cycle of the strobe, that strobe produces no pulse.
- R5: Write-enable pulses while `ce_n` is held high produce no pulse, whatever their width.
- R6: While `supply_ok` is low, no strobe produces a pulse.
- R7: After `supply_ok` rises, a strobe that overlaps the first `LOCKOUT_CYCLES` cycles produces no pulse. A strobe that starts after them does.
- R8: A drop of `supply_ok` restarts the lockout from zero. A strobe issued right after supply returns is blocked again.
- R9: A strobe held far longer than `MIN_LOW_CYCLES` still gives exactly one pulse, at release. The width counter saturates and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| supply_ok | input | 1 | Supply-good flag, high when the supply is in range |
| prog_start | output | 1 | One-cycle request to begin a program cycle |

## Verification
The bench builds the guard with `MIN_LOW_CYCLES` = 4, `LOCKOUT_CYCLES` = 40 and two synchronizer stages. With these values, strobe widths on both sides of the filter threshold can be reached, including the exact threshold and one below it. Full lockout windows and repeated supply drops also fit in a short run. Random strobe widths from 1 to 10 cycles are mixed with output-enable glitches. The bench varies which enable ends the strobe, and adds directed runs for pulse latency, saturation and lockout restart.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic pwr_ok;
    } fpg_pins_t;

    localparam int FPG_PIN_BITS = $bits(fpg_pins_t);

    localparam fpg_pins_t FPG_PINS_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, pwr_ok: 1'b0};

    typedef struct packed {
        logic strobe;
        logic read_on;
    } fpg_strobe_t;

    function automatic fpg_strobe_t fpg_decode(fpg_pins_t p);
        fpg_strobe_t s;
        s.strobe  = !p.ce_n && !p.we_n;
        s.read_on = !p.oe_n;
        return s;
    endfunction

    function automatic int fpg_width(int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/fpg_sync.sv
module fpg_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fpg_lockout.sv
module fpg_lockout #(
    parameter int LOCKOUT_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    output logic ready
);
    localparam int CW = fpg_pkg::fpg_width(LOCKOUT_CYCLES);
    localparam logic [CW-1:0] LIMIT = CW'(LOCKOUT_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !pwr_ok)     cnt <= '0;
        else if (cnt != LIMIT)  cnt <= cnt + 1'b1;
    end

    assign ready = pwr_ok && (cnt == LIMIT);

    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |=> (cnt == '0) && !ready);

    p_ready_holds_r7: assert property (@(posedge clk) disable iff (rst)
        ready && pwr_ok |=> $stable(cnt));
endmodule

// File: rtl/fpg_filter.sv
module fpg_filter #(
    parameter int MIN_LOW_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  fpg_pkg::fpg_strobe_t sig,
    input  logic                ready,
    output logic                fire
);
    localparam int WW = fpg_pkg::fpg_width(MIN_LOW_CYCLES);
    localparam logic [WW-1:0] WMAX = WW'(MIN_LOW_CYCLES);

    logic [WW-1:0] width_cnt;
    logic          strobe_q;
    logic          clean;
    logic          cond_ok;
    logic          release_ev;

    assign cond_ok    = ready && !sig.read_on;
    assign release_ev = strobe_q && !sig.strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            width_cnt <= '0;
            strobe_q  <= 1'b0;
            clean     <= 1'b0;
            fire      <= 1'b0;
        end else begin
            strobe_q <= sig.strobe;
            fire     <= release_ev && clean && ready && (width_cnt == WMAX);
            if (sig.strobe) begin
                if (width_cnt != WMAX) width_cnt <= width_cnt + 1'b1;
                clean <= strobe_q ? (clean && cond_ok) : cond_ok;
            end else begin
                width_cnt <= '0;
                clean     <= 1'b0;
            end
        end
    end

    p_sat_r9: assert property (@(posedge clk) disable iff (rst)
        width_cnt <= WMAX);

    p_count_only_on_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        !sig.strobe |=> width_cnt == '0);
endmodule

// File: rtl/flash_prog_guard.sv
module flash_prog_guard #(
    parameter int SYNC_STAGES    = 2,
    parameter int MIN_LOW_CYCLES = 4,
    parameter int LOCKOUT_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic supply_ok,
    output logic prog_start
);
    import fpg_pkg::*;

    fpg_pins_t   pins_raw;
    fpg_pins_t   pins_s;
    fpg_strobe_t sig;
    logic        lock_ready;

    assign pins_raw = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n, pwr_ok: supply_ok};

    fpg_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (FPG_PIN_BITS),
        .RST_VAL(FPG_PINS_IDLE)
    ) u_sync (
        .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
    );

    assign sig = fpg_decode(pins_s);

    fpg_lockout #(.LOCKOUT_CYCLES(LOCKOUT_CYCLES)) u_lock (
        .clk(clk), .rst(rst), .pwr_ok(pins_s.pwr_ok), .ready(lock_ready)
    );

    fpg_filter #(.MIN_LOW_CYCLES(MIN_LOW_CYCLES)) u_filt (
        .clk(clk), .rst(rst), .sig(sig), .ready(lock_ready), .fire(prog_start)
    );

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        prog_start |=> !prog_start);

    p_only_when_ready_r7: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> $past(lock_ready));

    p_oe_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> $past(pins_s.oe_n, 2));

    p_ce_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> !$past(pins_s.ce_n, 2));
endmodule

// File: tb/tb_flash_prog_guard.sv
module tb_flash_prog_guard;
    localparam int MINW = 4;
    localparam int LOCK = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, supply_ok = 1'b0;
    logic prog_start;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int run_len = 0;
    bit done = 0;

    always #2 clk = ~clk;

    flash_prog_guard #(.SYNC_STAGES(2), .MIN_LOW_CYCLES(MINW), .LOCKOUT_CYCLES(LOCK)) dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .supply_ok(supply_ok), .prog_start(prog_start)
    );

    always @(negedge clk) begin
        if (prog_start === 1'b1) begin
            pulses++;
            run_len++;
            if (run_len == 2) begin
                checks++; errors++;
                $display("FAIL R2: pulse width %0d cycles, expected 1", run_len);
            end
        end else run_len = 0;
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int exp_pulses(int n, bit oe_glitch, int mode, bit ready);
        if (!ready || mode == 2 || oe_glitch || n < MINW) return 0;
        return 1;
    endfunction

    // mode 0: ce and we together; mode 1: ce held, we pulses; mode 2: ce high, we pulses
    task automatic strobe(int n, bit oe_glitch, int mode);
        @(negedge clk);
        if (mode == 1) begin ce_n = 1'b0; idle(2); end
        if (mode != 2) ce_n = 1'b0;
        we_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            oe_n = !(oe_glitch && i == n / 2);
            @(negedge clk);
        end
        oe_n = 1'b1;
        if (mode == 0) ce_n = 1'b1;
        we_n = 1'b1;
        idle(2);
        ce_n = 1'b1;
        idle(4);
    endtask

    task automatic ce_strobe(int n);
        @(negedge clk);
        we_n = 1'b0; idle(2);
        ce_n = 1'b0;
        idle(n);
        ce_n = 1'b1;
        idle(2);
        we_n = 1'b1;
        idle(4);
    endtask

    task automatic power_up(int settle);
        supply_ok = 1'b1;
        idle(settle);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int p0;
        void'($urandom(32'd1234));
        idle(4);
        rst = 1'b0;
        idle(2);
        check("R1 reset", int'(prog_start), 0);

        // R6: supply low
        p0 = pulses; strobe(MINW + 3, 0, 0);
        check("R6 supply low", pulses - p0, 0);

        // R7: strobe within lockout
        supply_ok = 1'b1;
        p0 = pulses; strobe(MINW + 2, 0, 0);
        check("R7 during lockout", pulses - p0, 0);
        idle(LOCK + 5);
        check("R1 no pulse after lockout without write", pulses - p0, 0);
        p0 = pulses; strobe(MINW + 2, 0, 0);
        check("R7 after lockout", pulses - p0, 1);

        // R2 latency
        p0 = pulses;
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0;
        idle(MINW + 1);
        we_n = 1'b1; ce_n = 1'b1;
        @(negedge clk); check("R2 latency edge1", int'(prog_start), 0);
        @(negedge clk); check("R2 latency edge2", int'(prog_start), 0);
        @(negedge clk); check("R2 latency edge3", int'(prog_start), 1);
        @(negedge clk); check("R2 pulse ends", int'(prog_start), 0);
        idle(3);
        check("R2 one pulse", pulses - p0, 1);

        // R3 thresholds
        p0 = pulses; strobe(MINW, 0, 0);     check("R3 exact min", pulses - p0, 1);
        p0 = pulses; strobe(MINW - 1, 0, 0); check("R3 one short", pulses - p0, 0);
        p0 = pulses; strobe(1, 0, 1);        check("R3 we glitch", pulses - p0, 0);
        p0 = pulses; ce_strobe(MINW - 1);    check("R3 ce short", pulses - p0, 0);
        p0 = pulses; ce_strobe(MINW);        check("R3 ce exact", pulses - p0, 1);

        // R4, R5
        p0 = pulses; strobe(MINW + 3, 1, 0); check("R4 oe glitch", pulses - p0, 0);
        p0 = pulses; strobe(MINW + 3, 0, 2); check("R5 ce high", pulses - p0, 0);

        // R9 long strobe
        p0 = pulses; strobe(MINW * 5 + 3, 0, 1); check("R9 long strobe", pulses - p0, 1);

        // R8 supply drop restarts lockout
        @(negedge clk); supply_ok = 1'b0; idle(3); supply_ok = 1'b1;
        p0 = pulses; strobe(MINW + 1, 0, 0); check("R8 after drop", pulses - p0, 0);
        idle(LOCK + 5);
        p0 = pulses; strobe(MINW + 1, 0, 0); check("R8 recovered", pulses - p0, 1);

        // random
        for (int k = 0; k < 60; k++) begin
            int n    = $urandom_range(1, 2 * MINW + 2);
            bit gl   = ($urandom_range(0, 4) == 0);
            int mode = $urandom_range(0, 2);
            p0 = pulses;
            strobe(n, gl, mode);
            check("R2/R3/R4/R5 random", pulses - p0, exp_pulses(n, gl, mode, 1'b1));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule